// File: doc/BRIEF.md
# Data-Side Burst Traffic Classifier

This block watches the pipelined address and data phases of a processor's data-side AHB layer. It turns every completed transfer into one-cycle increment strobes for an external bank of profiling counters. Generic strobes fire once per completed beat: read, write, and reads or writes into two peripheral bridge address windows. Class strobes fire once per burst, on its first (NONSEQ) beat. They mark a cache line fill, a half-line or full-line writeback, or a page table walk from the data or instruction side. The block infers these classes from the burst type, the direction and the HPROT attribute bits.

Attributes are decoded and latched when the address phase is accepted. A strobe is released only when the matching data phase ends with OKAY, or in the second cycle of an ERROR response. The counters therefore see exactly the transfers that the bus completed. An optional alignment filter suppresses the half-line writeback class for 4-beat write bursts that do not start on a 16-byte boundary. Most store-multiple bursts carry the same attributes and are removed this way.

Top module: `dside_xfer_classifier`

## Requirements
- R1: A NONSEQ read beat with HBURST = WRAP8 (3'b100) raises the line-fill strobe, evt_o[3].
- R2: A NONSEQ write beat with HBURST = INCR4 (3'b011) and HPROT equal to PROT_MATCH raises the half-line writeback strobe, evt_o[4]. The default PROT_MATCH is 4'b1111: bit3 cacheable, bit2 bufferable, bit1 privileged, bit0 data.
- R3: While align_chk_en_i is 1, the half-line writeback strobe additionally requires haddr_i[3:0] == 0. While align_chk_en_i is 0, the start address is not examined.
- R4: A NONSEQ write beat with HBURST = INCR8 (3'b101) and HPROT equal to PROT_MATCH raises the full-line writeback strobe, evt_o[5]. Any other HPROT value gives no writeback strobe.
- R5: A NONSEQ read beat with HBURST = SINGLE (3'b000) and HPROT[3:1] equal to PROT_MATCH[3:1] is a page walk. It raises evt_o[6] (data side) when HPROT[0] = 1 and evt_o[7] (instruction side) when HPROT[0] = 0. At most one of evt_o[7:3] is set in any cycle.
- R6: Every completed read beat raises evt_o[0] and every completed write beat raises evt_o[1], including beats that are also classified. A NONSEQ SINGLE beat of either direction raises evt_o[2], including page walks.
- R7: A beat with (haddr_i & WIN_MASK) == WIN0_BASE raises evt_o[8] on a read or evt_o[9] on a write. A beat in WIN1_BASE raises evt_o[10] on a read or evt_o[11] on a write. These strobes fire once per beat.
- R8: HRESP is encoded OKAY=00, ERROR=01, RETRY=10, SPLIT=11. Strobes fire only for a pending transfer at a rising edge with hready_i = 1 and HRESP of OKAY or ERROR. Wait states (hready_i = 0), RETRY and SPLIT produce no strobe.
- R9: Strobes are registered. They are high for exactly the one cycle that follows the completing clock edge.
- R10: IDLE (2'b00) and BUSY (2'b01) beats produce no strobe. SEQ (2'b11) beats produce only the per-beat strobes evt_o[0], evt_o[1] and evt_o[11:8].
- R11: While reset is asserted, and until its synchronized release, evt_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| htrans_i | input | 2 | Transfer type of the current address phase |
| hburst_i | input | 3 | Burst type of the current address phase |
| hwrite_i | input | 1 | Direction, 1 = write |
| hprot_i | input | 4 | Protection attributes |
| haddr_i | input | ADDR_W | Transfer address |
| hready_i | input | 1 | Layer ready; high ends a data phase and accepts an address phase |
| hresp_i | input | 2 | Slave response |
| align_chk_en_i | input | 1 | Enables the 16-byte start-alignment filter for half-line writebacks |
| evt_o | output | 12 | One-cycle increment strobes, bit order as in R1 to R7 |

## Verification
Several properties are checked on every cycle. A strobe is never emitted unless the previous edge completed a data phase with OKAY or ERROR. Latched attributes stay frozen through wait states, and an idle accepted address leaves nothing pending. The class strobes are mutually exclusive. A fill always comes with a read, a writeback with a write, and a page walk with a single-burst read. Other behaviour is visible only through the bench's scenarios. These are the protection-pattern and alignment discrimination, the window decode, the suppression of RETRY and SPLIT, the single-beat-late timing under wait states, and the per-beat rather than per-burst behaviour of SEQ beats.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  localparam int unsigned NUM_WIN     = 2;
  localparam int unsigned EV_RD       = 0;
  localparam int unsigned EV_WR       = 1;
  localparam int unsigned EV_SINGLE   = 2;
  localparam int unsigned EV_FILL     = 3;
  localparam int unsigned EV_WB_HALF  = 4;
  localparam int unsigned EV_WB_FULL  = 5;
  localparam int unsigned EV_WALK_D   = 6;
  localparam int unsigned EV_WALK_I   = 7;
  localparam int unsigned EV_WIN_BASE = 8;
  localparam int unsigned EVT_W       = EV_WIN_BASE + 2 * NUM_WIN;

  typedef logic [EVT_W-1:0] evt_vec_t;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [2:0] {
    BU_SINGLE = 3'd0,
    BU_INCR   = 3'd1,
    BU_WRAP4  = 3'd2,
    BU_INCR4  = 3'd3,
    BU_WRAP8  = 3'd4,
    BU_INCR8  = 3'd5,
    BU_WRAP16 = 3'd6,
    BU_INCR16 = 3'd7
  } burst_e;

  typedef enum logic [1:0] {
    RS_OKAY  = 2'b00,
    RS_ERROR = 2'b01,
    RS_RETRY = 2'b10,
    RS_SPLIT = 2'b11
  } resp_e;

endpackage

// File: rtl/ctc_decode.sv
module ctc_decode
  import ctc_pkg::*;
#(
  parameter int unsigned                   ADDR_W          = 32,
  parameter logic [3:0]                    PROT_MATCH      = 4'b1111,
  parameter int unsigned                   HALF_LINE_BYTES = 16,
  parameter logic [NUM_WIN*ADDR_W-1:0]     WIN_BASES       = {32'h4001_0000, 32'h4000_0000},
  parameter logic [ADDR_W-1:0]             WIN_MASK        = 32'hFFFF_0000
) (
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic              hwrite,
  input  logic [3:0]        hprot,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              align_en,
  output logic              active,
  output evt_vec_t          cls
);

  localparam int unsigned ALIGN_LSB = $clog2(HALF_LINE_BYTES);

  trans_e tr;
  burst_e bu;
  logic   first_beat;
  logic   prot_full;
  logic   prot_walk;
  logic   aligned;
  logic   half_ok;
  logic [NUM_WIN-1:0]   win_hit;
  logic [2*NUM_WIN-1:0] win_evt;

  assign tr         = trans_e'(htrans);
  assign bu         = burst_e'(hburst);
  assign active     = (tr == TR_NSEQ) || (tr == TR_SEQ);
  assign first_beat = (tr == TR_NSEQ);
  assign prot_full  = (hprot == PROT_MATCH);
  assign prot_walk  = (hprot[3:1] == PROT_MATCH[3:1]);
  assign aligned    = (haddr[ALIGN_LSB-1:0] == '0);
  assign half_ok    = !align_en || aligned;

  // one address window comparator per bridge, read and write split
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_hit[g]         = ((haddr & WIN_MASK) == WIN_BASES[g*ADDR_W +: ADDR_W]);
    assign win_evt[2*g]       = win_hit[g] && !hwrite;
    assign win_evt[2*g + 1]   = win_hit[g] &&  hwrite;
  end

  always_comb begin
    cls = '0;
    if (active) begin
      cls[EV_RD] = !hwrite;
      cls[EV_WR] =  hwrite;
      cls[EV_WIN_BASE +: 2*NUM_WIN] = win_evt;
      if (first_beat) begin
        cls[EV_SINGLE]  = (bu == BU_SINGLE);
        cls[EV_FILL]    = !hwrite && (bu == BU_WRAP8);
        cls[EV_WB_HALF] =  hwrite && (bu == BU_INCR4) && prot_full && half_ok;
        cls[EV_WB_FULL] =  hwrite && (bu == BU_INCR8) && prot_full;
        cls[EV_WALK_D]  = !hwrite && (bu == BU_SINGLE) && prot_walk &&  hprot[0];
        cls[EV_WALK_I]  = !hwrite && (bu == BU_SINGLE) && prot_walk && !hprot[0];
      end
    end
  end

endmodule

// File: rtl/ctc_addr_stage.sv
module ctc_addr_stage
  import ctc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hready,
  input  logic     active,
  input  evt_vec_t cls,
  output logic     pend_vld,
  output evt_vec_t pend_cls
);

  logic     load_en;
  logic     vld_d, vld_q;
  evt_vec_t cls_d, cls_q;

  // an address phase is accepted only on a ready edge
  assign load_en = hready;

  always_comb begin
    vld_d = active;
    cls_d = active ? cls : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cls_q <= '0;
    end else if (load_en) begin
      vld_q <= vld_d;
      cls_q <= cls_d;
    end
  end

  assign pend_vld = vld_q;
  assign pend_cls = cls_q;

  assert_hold_in_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> ($stable(pend_vld) && $stable(pend_cls)));

  assert_idle_not_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && !active) |=> !pend_vld);

endmodule

// File: rtl/ctc_resp_gate.sv
module ctc_resp_gate
  import ctc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hready,
  input  logic [1:0] hresp,
  input  logic       pend_vld,
  input  evt_vec_t   pend_cls,
  output evt_vec_t   evt
);

  resp_e    rs;
  logic     resp_counts;
  logic     done;
  evt_vec_t evt_d, evt_q;

  assign rs          = resp_e'(hresp);
  assign resp_counts = (rs == RS_OKAY) || (rs == RS_ERROR);
  assign done        = pend_vld && hready && resp_counts;

  always_comb begin
    evt_d = done ? pend_cls : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign evt = evt_q;

  assert_strobe_needs_completion_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |-> ($past(hready) && (($past(hresp) == 2'b00) || ($past(hresp) == 2'b01))));

  assert_no_strobe_after_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> (evt == '0));

endmodule

// File: rtl/dside_xfer_classifier.sv
module dside_xfer_classifier
  import ctc_pkg::*;
#(
  parameter int unsigned       ADDR_W          = 32,
  parameter logic [3:0]        PROT_MATCH      = 4'b1111,
  parameter int unsigned       HALF_LINE_BYTES = 16,
  parameter logic [ADDR_W-1:0] WIN0_BASE       = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] WIN1_BASE       = 32'h4001_0000,
  parameter logic [ADDR_W-1:0] WIN_MASK        = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        htrans_i,
  input  logic [2:0]        hburst_i,
  input  logic              hwrite_i,
  input  logic [3:0]        hprot_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic              hready_i,
  input  logic [1:0]        hresp_i,
  input  logic              align_chk_en_i,
  output logic [11:0]       evt_o
);

  localparam logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = {WIN1_BASE, WIN0_BASE};

  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       active;
  evt_vec_t   cls;
  logic       pend_vld;
  evt_vec_t   pend_cls;
  evt_vec_t   evt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  ctc_decode #(
    .ADDR_W          (ADDR_W),
    .PROT_MATCH      (PROT_MATCH),
    .HALF_LINE_BYTES (HALF_LINE_BYTES),
    .WIN_BASES       (WIN_BASES),
    .WIN_MASK        (WIN_MASK)
  ) u_decode (
    .htrans   (htrans_i),
    .hburst   (hburst_i),
    .hwrite   (hwrite_i),
    .hprot    (hprot_i),
    .haddr    (haddr_i),
    .align_en (align_chk_en_i),
    .active   (active),
    .cls      (cls)
  );

  ctc_addr_stage u_addr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .hready   (hready_i),
    .active   (active),
    .cls      (cls),
    .pend_vld (pend_vld),
    .pend_cls (pend_cls)
  );

  ctc_resp_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .hready   (hready_i),
    .hresp    (hresp_i),
    .pend_vld (pend_vld),
    .pend_cls (pend_cls),
    .evt      (evt)
  );

  assign evt_o = evt;

  assert_fill_is_read_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    evt_o[EV_FILL] |-> (evt_o[EV_RD] && !evt_o[EV_WR]));

  assert_writeback_is_write_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (evt_o[EV_WB_HALF] || evt_o[EV_WB_FULL]) |-> evt_o[EV_WR]);

  assert_class_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(evt_o[EV_WALK_I:EV_FILL]));

  assert_walk_is_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (evt_o[EV_WALK_D] || evt_o[EV_WALK_I]) |-> (evt_o[EV_SINGLE] && evt_o[EV_RD]));

  assert_dir_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(evt_o[EV_RD] && evt_o[EV_WR]));

  assert_quiet_in_reset_R11: assert property (@(posedge clk)
    !rst_n_s |-> (evt_o == '0));

endmodule

// File: tb/sim_dside_xfer_classifier.sv
module sim_dside_xfer_classifier;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  htrans;
  logic [2:0]  hburst;
  logic        hwrite;
  logic [3:0]  hprot;
  logic [31:0] haddr;
  logic        hready;
  logic [1:0]  hresp;
  logic        align;
  logic [11:0] evt;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int          at;
    logic [11:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dside_xfer_classifier u0 (
    .clk(clk), .rst_n(rst_n), .htrans_i(htrans), .hburst_i(hburst),
    .hwrite_i(hwrite), .hprot_i(hprot), .haddr_i(haddr), .hready_i(hready),
    .hresp_i(hresp), .align_chk_en_i(align), .evt_o(evt)
  );

  // expected strobes derived from the requirements
  function automatic logic [11:0] model(logic hw, logic [2:0] bu, logic [3:0] pr,
                                        logic [31:0] a, logic first);
    logic [11:0] m = '0;
    m[0] = !hw;
    m[1] = hw;
    if (first) begin
      if (bu == 3'd0) m[2] = 1'b1;
      if (!hw && bu == 3'd4) m[3] = 1'b1;
      if (hw && bu == 3'd3 && pr == 4'hF && (!align || a[3:0] == 4'h0)) m[4] = 1'b1;
      if (hw && bu == 3'd5 && pr == 4'hF) m[5] = 1'b1;
      if (!hw && bu == 3'd0 && pr[3:1] == 3'b111) begin
        if (pr[0]) m[6] = 1'b1; else m[7] = 1'b1;
      end
    end
    if (a[31:16] == 16'h4000) begin m[8]  = !hw; m[9]  = hw; end
    if (a[31:16] == 16'h4001) begin m[10] = !hw; m[11] = hw; end
    return m;
  endfunction

  task automatic push(int at, logic [11:0] e, string tag);
    exp_t it;
    it.at = at; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic bus_idle();
    htrans = 2'b00; hready = 1'b1; hresp = 2'b00;
  endtask

  // one-beat transfer; rk: 0 OKAY, 1 ERROR, 2 RETRY, 3 SPLIT
  task automatic single(logic hw, logic [2:0] bu, logic [3:0] pr, logic [31:0] a,
                        int waits, int rk, string tag);
    int c;
    @(negedge clk);
    c = cyc;
    htrans = 2'b10; hburst = bu; hwrite = hw; hprot = pr; haddr = a;
    hready = 1'b1; hresp = 2'b00;
    if (rk == 0) begin
      push(c + 2 + waits, model(hw, bu, pr, a, 1'b1), tag);
      for (int i = 0; i < waits; i++) begin
        @(negedge clk);
        htrans = 2'b00; hready = 1'b0; hresp = 2'b00;
      end
      @(negedge clk);
      bus_idle();
    end else begin
      push(c + 3, (rk == 1) ? model(hw, bu, pr, a, 1'b1) : 12'h000, tag);
      @(negedge clk);
      htrans = 2'b00; hready = 1'b0; hresp = 2'(rk);
      @(negedge clk);
      hready = 1'b1;
    end
  endtask

  task automatic burst(logic hw, logic [2:0] bu, logic [3:0] pr, logic [31:0] a,
                       int beats, string tag);
    int c;
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      c = cyc;
      htrans = (i == 0) ? 2'b10 : 2'b11; hburst = bu; hwrite = hw; hprot = pr;
      haddr = a + 32'(4 * i); hready = 1'b1; hresp = 2'b00;
      push(c + 2, model(hw, bu, pr, a + 32'(4 * i), i == 0), tag);
    end
    @(negedge clk);
    bus_idle();
  endtask

  task automatic quiet_beat(logic [1:0] tr, string tag);
    @(negedge clk);
    push(cyc + 2, 12'h000, tag);
    htrans = tr; hburst = 3'd0; hwrite = 1'b0; hprot = 4'hF;
    haddr = 32'h4000_0000; hready = 1'b1; hresp = 2'b00;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard at the cycle each result is due
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (sb.size() > 0 && sb[0].at == cyc) begin
          vectors++;
          if (evt !== sb[0].exp) begin
            miscompares++;
            $display("FAIL %s actual=%03h expected=%03h", sb[0].tag, evt, sb[0].exp);
          end
          void'(sb.pop_front());
        end else if (evt !== 12'h000) begin
          vectors++;
          miscompares++;
          $display("FAIL R8 unexpected strobe actual=%03h expected=000", evt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; align = 1'b1;
    hburst = 3'd0; hwrite = 1'b0; hprot = 4'h0; haddr = '0;
    bus_idle();
    htrans = 2'b10; // activity during reset must be ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      vectors++;
      if (evt !== 12'h000) begin
        miscompares++;
        $display("FAIL R11 reset actual=%03h expected=000", evt);
      end
    end
    bus_idle();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    single(1'b0, 3'd0, 4'b0011, 32'h0000_1000, 0, 0, "R6 plain single read");
    single(1'b1, 3'd0, 4'b0011, 32'h0000_1004, 0, 0, "R6 plain single write");
    single(1'b0, 3'd0, 4'hF,    32'h0000_2000, 0, 0, "R5 data-side walk");
    single(1'b0, 3'd0, 4'hE,    32'h0000_2004, 0, 0, "R5 instruction-side walk");
    single(1'b0, 3'd0, 4'b0111, 32'h0000_2008, 0, 0, "R5 non-cacheable is no walk");
    burst (1'b0, 3'd4, 4'hF,    32'h0000_3000, 8,    "R1 R10 wrap8 fill");
    burst (1'b1, 3'd3, 4'hF,    32'h0000_4000, 4,    "R2 aligned half writeback");
    burst (1'b1, 3'd3, 4'hF,    32'h0000_4004, 4,    "R3 unaligned filtered");
    align = 1'b0;
    burst (1'b1, 3'd3, 4'hF,    32'h0000_4008, 4,    "R3 filter off");
    align = 1'b1;
    burst (1'b1, 3'd3, 4'b0011, 32'h0000_4010, 4,    "R2 wrong prot no writeback");
    burst (1'b1, 3'd5, 4'hF,    32'h0000_5000, 8,    "R4 full writeback");
    burst (1'b1, 3'd5, 4'b1011, 32'h0000_5020, 8,    "R4 wrong prot");
    single(1'b0, 3'd0, 4'b0011, 32'h4000_0010, 0, 0, "R7 window0 read");
    single(1'b1, 3'd0, 4'b0011, 32'h4001_0020, 0, 0, "R7 window1 write");
    burst (1'b1, 3'd1, 4'b0011, 32'h4000_0100, 4,    "R7 window0 write burst");
    burst (1'b0, 3'd1, 4'b0011, 32'h4001_0100, 3,    "R7 window1 read burst");
    single(1'b0, 3'd0, 4'hF,    32'h0000_6000, 3, 0, "R9 strobe after wait states");
    single(1'b1, 3'd5, 4'hF,    32'h0000_6100, 0, 1, "R8 error second cycle counts");
    single(1'b0, 3'd0, 4'hF,    32'h0000_6200, 0, 2, "R8 retry not counted");
    single(1'b1, 3'd0, 4'b0011, 32'h4000_0200, 0, 3, "R8 split not counted");
    quiet_beat(2'b00, "R10 idle ignored");
    quiet_beat(2'b01, "R10 busy ignored");
    burst (1'b0, 3'd0, 4'hF,    32'h0000_7000, 1,    "R9 back-to-back A");
    burst (1'b1, 3'd5, 4'hF,    32'h4001_0040, 1,    "R9 back-to-back B");

    while (sb.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule